// File: doc/BRIEF.md
# PCI Target Data-Phase Tracker

This block watches one 32-bit PCI bus segment on behalf of a bridge port that is acting as target. When a new transaction begins it latches the address and the bus command from the single address phase. It then follows the FRAME#, IRDY#, TRDY# and STOP# handshake clock by clock. For every data phase it reports whether the phase completed, whether data actually moved, and whether this was the final phase of the transaction. It also keeps a running dword address for the data-path logic next to it.

Only linear-increment bursts are supported. When the two low address bits seen in the address phase are anything other than zero, the tracker raises a disconnect request. The target logic then stops the transaction after its first transfer, and the tracked address is frozen. All outputs are registered. Each one reflects the bus values sampled at the preceding rising clock edge. Reset is synchronous and active low.

Top module: `pci_dphase_tracker`

## Requirements
- R1: While reset is low, at the next clock edge busy, xfer, phase_done, last_phase and disc_req all go to 0, and cur_addr, cmd and phase_cnt go to 0.
- R2: A transaction starts only at a clock where the tracker is idle, FRAME# is sampled low, and FRAME# and IRDY# were both sampled high at the previous clock edge. A bus that is still busy when reset is released therefore starts nothing. On a start, cur_addr takes AD, cmd takes the C/BE# value as driven, phase_cnt clears and busy goes to 1.
- R3: phase_done pulses for a data-phase clock in which IRDY# is low and either TRDY# or STOP# is low.
- R4: xfer pulses only for a data-phase clock in which IRDY# and TRDY# are both low.
- R5: last_phase pulses for a completed phase in which either FRAME# is high and TRDY# is low, or STOP# is low. The tracker then leaves the data state.
- R6: When AD[1:0] was 00 in the address phase, cur_addr advances by 4 after each transfer. A completed phase that moves no data leaves cur_addr unchanged, and so does a wait state.
- R7: When AD[1:0] was not 00 in the address phase, disc_req is 1 from the clock after the address phase until the final phase is seen, and cur_addr stays at the captured value for the whole transaction.
- R8: After the final phase the tracker stays busy until FRAME# and IRDY# are both sampled high. No new transaction can start before that. After that clock busy is 0.
- R9: phase_cnt counts completed data phases of the current transaction and saturates at 255 instead of wrapping.
- R10: xfer, phase_done and last_phase stay 0 for clocks sampled outside the data state, whatever the handshake lines do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_n | input | 1 | FRAME#, active low |
| irdy_n | input | 1 | IRDY#, active low |
| trdy_n | input | 1 | TRDY#, active low |
| stop_n | input | 1 | STOP#, active low |
| ad | input | 32 | Address/data bus |
| cbe_n | input | 4 | Command / byte enables, active low |
| busy | output | 1 | A transaction is being tracked |
| cmd | output | 4 | Command captured in the address phase |
| cur_addr | output | 32 | Current dword address |
| xfer | output | 1 | Data moved in the sampled clock |
| phase_done | output | 1 | A data phase completed in the sampled clock |
| last_phase | output | 1 | The completed phase was the final one |
| disc_req | output | 1 | Disconnect requested (non-linear burst) |
| phase_cnt | output | 8 | Completed phases in this transaction, saturating |

## Verification
The hardest state to reach from the ports is the saturated phase counter. It needs a single burst of more than 255 completed phases, with the address still advancing correctly across all of them. One directed burst of 300 transfers, with random wait states, drives the tracker there. Two other conditions need hand-built sequences. The first is a bus that is still mid-transaction when reset is released. The second is FRAME# asserted again during the drain after a STOP# termination. Random transactions then mix linear and non-linear addresses, wait states, retries and disconnects. A bench model built from the requirements predicts every output on every clock.

// File: rtl/pci_dtrk_pkg.sv
// Package: shared types for the PCI target data-phase tracker.
// Assumes a 32-bit, single-address-phase bus; all handshake lines active low.
package pci_dtrk_pkg;

    // Tracker state: idle, inside data phases, draining to an idle bus
    typedef enum logic [1:0] {
        TRK_IDLE  = 2'd0,
        TRK_DATA  = 2'd1,
        TRK_DRAIN = 2'd2
    } trk_state_t;

    // Per-clock classification of one sampled data-phase clock
    typedef struct packed {
        logic done;
        logic xfer;
        logic last;
    } phase_ev_t;

    localparam phase_ev_t PHASE_EV_NONE = '{done: 1'b0, xfer: 1'b0, last: 1'b0};

endpackage

// File: rtl/pci_dtrk_start.sv
// Module: address-phase detector.
// Flags a start when the tracker is idle, FRAME# is sampled low, and the
// previous clock showed an idle bus (FRAME# and IRDY# both high).
// Assumes: the previous-idle history resets to "not idle", so a bus that is
// mid-transaction at reset release is never mistaken for a new address phase.
module pci_dtrk_start (
    input  logic clk,
    input  logic rst_n,
    input  logic in_idle,
    input  logic frame_n,
    input  logic irdy_n,
    output logic start
);

    logic bus_was_idle_q;

    // Remember whether the bus was idle at the previous edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_was_idle_q <= 1'b0;
        end else begin
            bus_was_idle_q <= frame_n & irdy_n;
        end
    end

    // Start condition: first FRAME# assertion after an idle clock
    always_comb begin
        start = in_idle & ~frame_n & bus_was_idle_q;
    end

endmodule

// File: rtl/pci_dtrk_classify.sv
// Module: data-phase classifier.
// Decodes completion, transfer and final-phase conditions from the
// handshake lines while the tracker is in the data state, and registers
// them into one-clock strobes.
// Assumes: handshake inputs are sampled at the rising edge of clk.
module pci_dtrk_classify
    import pci_dtrk_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      in_data,
    input  logic      frame_n,
    input  logic      irdy_n,
    input  logic      trdy_n,
    input  logic      stop_n,
    output phase_ev_t ev,
    output phase_ev_t ev_q
);

    logic completes;

    // Decode the current clock's data-phase events
    always_comb begin
        completes = ~irdy_n & (~trdy_n | ~stop_n);
        ev        = PHASE_EV_NONE;
        if (in_data) begin
            ev.done = completes;
            ev.xfer = ~irdy_n & ~trdy_n;
            ev.last = completes & ((frame_n & ~trdy_n) | ~stop_n);
        end
    end

    // Register the events into strobes for the outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_q <= PHASE_EV_NONE;
        end else begin
            ev_q <= ev;
        end
    end

    // R3: a completion strobe needs IRDY# low in a data-state clock
    assert_done_bus_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ev_q.done |-> ($past(~irdy_n) && $past(in_data)));

    // R4: data moves only with IRDY# and TRDY# both low
    assert_xfer_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ev_q.xfer |-> ($past(~irdy_n) && $past(~trdy_n)));

    // R5: final phase needs FRAME# high or STOP# low
    assert_last_bus_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ev_q.last |-> ($past(frame_n) || $past(~stop_n)));

endmodule

// File: rtl/pci_dtrk_addr.sv
// Module: address, command and phase-count keeper.
// Loads address/command at the address phase, decides linear versus
// non-linear mode from the two low address bits, advances the address by
// one dword per transfer in linear mode, holds a disconnect request in
// non-linear mode, and counts completed phases.
// Assumes: ev is already gated to the data state by the classifier.
module pci_dtrk_addr
    import pci_dtrk_pkg::*;
#(
    parameter int ADDR_W       = 32,
    parameter int CMD_W        = 4,
    parameter int CNT_W        = 8,
    parameter int STEP_BYTES   = 4,
    parameter bit CNT_SATURATE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] ad,
    input  logic [CMD_W-1:0]  cbe_n,
    input  phase_ev_t         ev,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [CMD_W-1:0]  cmd,
    output logic              disc_req,
    output logic [CNT_W-1:0]  phase_cnt
);

    localparam int               LOW_BITS = $clog2(STEP_BYTES);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [ADDR_W-1:0] STEP    = ADDR_W'(STEP_BYTES);

    logic              linear_q;
    logic [CNT_W-1:0]  cnt_next;

    // Next phase count: wrap or saturate as the parameter selects
    generate
        if (CNT_SATURATE) begin : g_sat
            always_comb begin
                cnt_next = (phase_cnt == CNT_MAX) ? phase_cnt : phase_cnt + 1'b1;
            end
        end else begin : g_wrap
            always_comb begin
                cnt_next = phase_cnt + 1'b1;
            end
        end
    endgenerate

    // Capture at address phase, then track address, mode and count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr  <= '0;
            cmd       <= '0;
            linear_q  <= 1'b0;
            disc_req  <= 1'b0;
            phase_cnt <= '0;
        end else if (start) begin
            cur_addr  <= ad;
            cmd       <= cbe_n;
            linear_q  <= (ad[LOW_BITS-1:0] == '0);
            disc_req  <= (ad[LOW_BITS-1:0] != '0);
            phase_cnt <= '0;
        end else begin
            if (ev.xfer && linear_q) begin
                cur_addr <= cur_addr + STEP;
            end
            if (ev.done) begin
                phase_cnt <= cnt_next;
            end
            if (ev.last) begin
                disc_req <= 1'b0;
            end
        end
    end

    // R6: each linear transfer moves the address by one step
    assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev.xfer && linear_q && !start) |=> (cur_addr == $past(cur_addr) + STEP));

    // R7: while a disconnect is pending the address does not move
    assert_disc_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (disc_req && !start) |=> $stable(cur_addr));

    // R9: a saturated count stays saturated until the next start
    assert_cnt_sat_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (CNT_SATURATE && phase_cnt == CNT_MAX && !start) |=> (phase_cnt == CNT_MAX));

endmodule

// File: rtl/pci_dphase_tracker.sv
// Module: PCI target data-phase tracker (top).
// Sequences idle -> data -> drain around the address-phase detector, the
// data-phase classifier and the address keeper; all outputs are registered.
// Assumes: one 32-bit single address phase per transaction, synchronous
// active-low reset, all bus lines sampled on the rising PCI clock edge.
module pci_dphase_tracker
    import pci_dtrk_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CMD_W  = 4,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_n,
    input  logic              irdy_n,
    input  logic              trdy_n,
    input  logic              stop_n,
    input  logic [ADDR_W-1:0] ad,
    input  logic [CMD_W-1:0]  cbe_n,
    output logic              busy,
    output logic [CMD_W-1:0]  cmd,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              xfer,
    output logic              phase_done,
    output logic              last_phase,
    output logic              disc_req,
    output logic [CNT_W-1:0]  phase_cnt
);

    trk_state_t state_q, state_d;
    phase_ev_t  ev, ev_q;
    logic       start;

    pci_dtrk_start u_start (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_idle (state_q == TRK_IDLE),
        .frame_n (frame_n),
        .irdy_n  (irdy_n),
        .start   (start)
    );

    pci_dtrk_classify u_classify (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_data (state_q == TRK_DATA),
        .frame_n (frame_n),
        .irdy_n  (irdy_n),
        .trdy_n  (trdy_n),
        .stop_n  (stop_n),
        .ev      (ev),
        .ev_q    (ev_q)
    );

    pci_dtrk_addr #(
        .ADDR_W (ADDR_W),
        .CMD_W  (CMD_W),
        .CNT_W  (CNT_W)
    ) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .ad        (ad),
        .cbe_n     (cbe_n),
        .ev        (ev),
        .cur_addr  (cur_addr),
        .cmd       (cmd),
        .disc_req  (disc_req),
        .phase_cnt (phase_cnt)
    );

    // Next-state decode for the transaction sequencer
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TRK_IDLE:  if (start) state_d = TRK_DATA;
            TRK_DATA:  if (ev.last) state_d = TRK_DRAIN;
            TRK_DRAIN: if (frame_n && irdy_n) state_d = TRK_IDLE;
            default:   state_d = TRK_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TRK_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Drive the registered outputs
    always_comb begin
        busy       = (state_q != TRK_IDLE);
        xfer       = ev_q.xfer;
        phase_done = ev_q.done;
        last_phase = ev_q.last;
    end

    // R8: draining ends exactly when the bus is sampled idle
    assert_drain_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TRK_DRAIN && frame_n && irdy_n) |=> (state_q == TRK_IDLE));

    // R8: a start can never come straight out of the drain state
    assert_no_start_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TRK_DRAIN) |=> (state_q != TRK_DATA));

    // R10: strobes are silent while idle
    assert_quiet_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TRK_IDLE) |-> (!xfer && !phase_done && !last_phase));

    // R5: a final phase always moves the tracker into draining
    assert_last_leaves_R5: assert property (@(posedge clk) disable iff (!rst_n)
        last_phase |-> (state_q == TRK_DRAIN));

endmodule

// File: tb/pci_dphase_tracker_bench.sv
module pci_dphase_tracker_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_n = 1'b1, irdy_n = 1'b1, trdy_n = 1'b1, stop_n = 1'b1;
    logic [31:0] ad = '0;
    logic [3:0]  cbe_n = '0;
    logic        busy, xfer, phase_done, last_phase, disc_req;
    logic [3:0]  cmd;
    logic [31:0] cur_addr;
    logic [7:0]  phase_cnt;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;

    // model state: 0 idle, 1 data, 2 drain
    int          m_st = 0;
    logic        m_prev_idle = 1'b0;
    logic [31:0] m_addr = '0;
    logic [3:0]  m_cmd = '0;
    logic        m_lin = 1'b0, m_disc = 1'b0;
    logic [7:0]  m_cnt = '0;
    logic        m_xfer = 1'b0, m_done = 1'b0, m_last = 1'b0;

    always #4 clk = ~clk;

    pci_dphase_tracker u_pci_dphase_tracker (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
        .trdy_n(trdy_n), .stop_n(stop_n), .ad(ad), .cbe_n(cbe_n),
        .busy(busy), .cmd(cmd), .cur_addr(cur_addr), .xfer(xfer),
        .phase_done(phase_done), .last_phase(last_phase),
        .disc_req(disc_req), .phase_cnt(phase_cnt)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    function automatic logic f_done(logic i, logic t, logic s);
        return !i && (!t || !s);
    endfunction

    // one clock: drive, advance the model from the requirements, compare
    task automatic tick(input logic f, input logic i, input logic t, input logic s,
                        input logic [31:0] a, input logic [3:0] c);
        logic d, x, l, st;
        @(negedge clk);
        frame_n = f; irdy_n = i; trdy_n = t; stop_n = s; ad = a; cbe_n = c;
        if (!rst_n) begin
            m_st = 0; m_prev_idle = 0; m_addr = 0; m_cmd = 0; m_lin = 0;
            m_disc = 0; m_cnt = 0; m_xfer = 0; m_done = 0; m_last = 0;
        end else begin
            d = (m_st == 1) && f_done(i, t, s);
            x = (m_st == 1) && !i && !t;
            l = d && ((f && !t) || !s);
            st = (m_st == 0) && !f && m_prev_idle;
            if (st) begin
                m_addr = a; m_cmd = c; m_lin = (a[1:0] == 2'b00);
                m_disc = (a[1:0] != 2'b00); m_cnt = 0; m_st = 1;
            end else if (m_st == 1) begin
                if (x && m_lin) m_addr = m_addr + 4;
                if (d && m_cnt != 8'hFF) m_cnt = m_cnt + 1;
                if (l) begin m_st = 2; m_disc = 0; end
            end else if (m_st == 2) begin
                if (f && i) m_st = 0;
            end
            m_prev_idle = f && i;
            m_xfer = x; m_done = d; m_last = l;
        end
        @(posedge clk);
        #2;
        check(rst_n ? "R3 phase_done" : "R1 phase_done", 32'(phase_done), 32'(m_done));
        check(rst_n ? "R4 xfer"       : "R1 xfer",       32'(xfer),       32'(m_xfer));
        check(rst_n ? "R5 last_phase" : "R1 last_phase", 32'(last_phase), 32'(m_last));
        check(rst_n ? "R6 cur_addr"   : "R1 cur_addr",   cur_addr,        m_addr);
        check(rst_n ? "R7 disc_req"   : "R1 disc_req",   32'(disc_req),   32'(m_disc));
        check(rst_n ? "R8 busy"       : "R1 busy",       32'(busy),       32'(m_st != 0));
        check(rst_n ? "R2 cmd"        : "R1 cmd",        32'(cmd),        32'(m_cmd));
        check(rst_n ? "R9 phase_cnt"  : "R1 phase_cnt",  32'(phase_cnt),  32'(m_cnt));
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) tick(1, 1, 1, 1, $urandom, $urandom);
    endtask

    // one transaction: wants nph transfers; pw = % wait, ps = % STOP#
    task automatic txn(input logic [31:0] a, input logic [3:0] c, input int nph,
                       input int pw, input int ps);
        int left = nph;
        int guard = 0;
        logic fdone = 0;
        logic i, t, s, f;
        tick(0, 1, 1, 1, a, c);
        while (m_st == 1 && guard < 5000) begin
            guard++;
            i = fdone ? 1'b0 : (($urandom % 100) < pw);
            t = (($urandom % 100) < pw);
            s = !((($urandom % 100) < ps));
            f = fdone || (left <= 1 && !i);
            if (f && !i) fdone = 1;
            tick(f, i, t, s, $urandom, $urandom);
            if (m_xfer) left--;
        end
        if (!frame_n) tick(1, 0, 1, 1, $urandom, $urandom);
        tick(1, 1, 1, 1, $urandom, $urandom);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual %0d expected < 150000 cycles", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_c0de));
        // R1: reset with a busy bus
        rst_n = 0;
        tick(0, 0, 0, 1, 32'h1234_5678, 4'h7);
        tick(0, 0, 0, 1, 32'h1234_5678, 4'h7);
        // R2: bus still busy after release: no start
        rst_n = 1;
        tick(0, 0, 0, 1, 32'h1111_0000, 4'h6);
        tick(0, 0, 1, 1, 32'h1111_0000, 4'h6);
        check("R2 no start on busy bus", 32'(busy), 32'd0);
        idle(2);
        // R6: linear burst, no waits
        txn(32'h0000_1000, 4'h7, 4, 0, 0);
        // R7: non-linear address, disconnect
        txn(32'h0000_2002, 4'h6, 3, 20, 30);
        txn(32'h0000_3001, 4'h7, 5, 0, 0);
        // R5: single phase with FRAME# already high
        tick(0, 1, 1, 1, 32'h0000_4000, 4'hF);
        tick(1, 0, 0, 1, 32'h0, 4'h0);
        tick(1, 1, 1, 1, 32'h0, 4'h0);
        // R3/R4: retry (STOP# without TRDY#): done and last, no transfer
        tick(0, 1, 1, 1, 32'h0000_5000, 4'h7);
        tick(0, 0, 1, 0, 32'h0, 4'h0);
        check("R6 retry keeps address", cur_addr, 32'h0000_5000);
        // R8: FRAME# asserted again during drain: no start
        tick(0, 0, 1, 1, 32'h0000_6000, 4'h6);
        check("R8 still draining", 32'(busy), 32'd1);
        tick(1, 0, 1, 1, 32'h0, 4'h0);
        tick(1, 1, 1, 1, 32'h0, 4'h0);
        check("R8 idle after bus idle", 32'(busy), 32'd0);
        // R10: idle bus handshake noise gives no strobes
        tick(1, 0, 0, 0, 32'h0, 4'h0);
        tick(1, 1, 0, 0, 32'h0, 4'h0);
        check("R10 no strobe outside data", 32'({xfer, phase_done, last_phase}), 32'd0);
        // back-to-back with one idle clock
        txn(32'h0000_7000, 4'h7, 2, 10, 0);
        txn(32'h0000_8000, 4'h6, 2, 10, 0);
        // R9: long burst saturates the counter
        txn(32'h0001_0000, 4'h7, 300, 15, 0);
        check("R9 saturated", 32'(phase_cnt), 32'd255);
        // random mix
        for (int k = 0; k < 60; k++) begin
            txn({$urandom} & 32'hFFFF_FFFF, 4'($urandom), 1 + ($urandom % 12),
                $urandom % 40, $urandom % 15);
            if ($urandom % 2) idle(1 + ($urandom % 3));
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule